// File: doc/BRIEF.md
# Flash Erase and Program Command Sequencer

This block sits between a CPU's register bus and a behavioural model of an on-chip flash array. The CPU sets up a control byte, a page number and then writes a command byte. The block only starts an erase when that byte carries one of two specific patterns. A page erase needs nothing else. A full-array erase also needs a separately armed enable bit and an asserted debug-port enable input.

External data-store writes are steered by a program-write-enable bit. When that bit is set, each write becomes a flash program operation, and programming can only clear bits. When the bit is clear, the write goes straight to a small data RAM.

While any flash operation runs, the block raises busy and drives one level strobe toward the flash macro for the whole duration. It refuses every new command or flash write until the operation finishes. The array is updated on the last busy cycle.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, every flash byte reads 0xFF, every RAM byte reads 0x00, fm_busy is 0 and the register bytes at offsets 0, 1 and 3 all read 0x00.
- R2: Writing 0x55 to the command register (offset 2) while idle erases exactly the page numbered by page register bits [7:1]. All bytes of that page become 0xFF, other pages are unchanged, and fm_busy stays high for PAGE_CYC cycles.
- R3: Writing 0xAA to the command register while idle, with the arm bit (control bit 1) equal to 1 and dbg_en high, sets every flash byte to 0xFF. fm_busy stays high for MASS_CYC cycles.
- R4: A write of 0xAA with the arm bit clear or dbg_en low leaves the array unchanged and keeps fm_busy low. It also sets status bit 1, which clears when the next operation starts.
- R5: Command bytes other than 0xAA and 0x55 change neither the array nor fm_busy.
- R6: The arm bit reads 0 after any 0xAA or 0x55 command write made while idle, whether or not that command was accepted.
- R7: With control bit 0 (program-write-enable) set, a data-store write to an idle block turns the flash byte into old AND new after PROG_CYC busy cycles. With bit 0 clear, the write lands in RAM location xw_addr[RAM_AW-1:0] and leaves flash and fm_busy untouched.
- R8: While fm_busy is 1, status bit 0 reads 1, and command writes and flash data-store writes are ignored. This includes their effect on the arm bit. Control and page register writes still take effect.
- R9: During an operation exactly one of fm_erase_page, fm_erase_all and fm_prog is high, matching the operation. None of them is high when idle.
- R10: Offset 0 reads {6'b0, arm, pwe}, offset 1 reads the page number in bits [7:1] with bit 0 reading 0, offset 2 reads 0x00, and offset 3 reads {6'b0, refused, busy}. A command write and a flash write in the same idle cycle start the command only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_en | input | 1 | Debug port enabled; required for full-array erase |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 control, 1 page, 2 command, 3 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| xw_en | input | 1 | External data-store write strobe |
| xw_addr | input | FA_W (10) | Data-store write address |
| xw_data | input | 8 | Data-store write byte |
| fl_rd_addr | input | FA_W (10) | Flash read address |
| fl_rd_data | output | 8 | Flash read byte |
| ram_rd_addr | input | RAM_AW (6) | RAM read address |
| ram_rd_data | output | 8 | RAM read byte |
| fm_erase_page | output | 1 | Page erase in progress |
| fm_erase_all | output | 1 | Full-array erase in progress |
| fm_prog | output | 1 | Byte program in progress |
| fm_busy | output | 1 | Any flash operation in progress |

## Verification
The assertions check several properties on every cycle. No command starts while busy. The latched operation stays constant through a busy window. The three macro strobes are mutually exclusive and one of them is present whenever busy. A full-array erase never begins without the debug enable. The arm bit drops after a command. A completed program never sets a bit, and a completed page erase leaves its page reading 0xFF.

Other behaviours need the bench's scenarios, which compare the whole array against a shadow model. These are that a refused full-array erase leaves every byte intact, that a page erase touches no neighbouring page, that busy lasts exactly the configured number of cycles, and that writes arriving during busy leave no trace.

// File: rtl/flcs_pkg.sv
package flcs_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PAGE = 2'd1,
    OP_MASS = 2'd2,
    OP_PROG = 2'd3
  } op_e;

  localparam logic [7:0] CODE_MASS = 8'hAA;
  localparam logic [7:0] CODE_PAGE = 8'h55;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_PAGE = 2'd1;
  localparam logic [1:0] RA_CMD  = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  // Programming only pulls bits low.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic is_erase_code(input logic [7:0] b);
    return (b == CODE_MASS) || (b == CODE_PAGE);
  endfunction

  // Translate a command byte into an operation, applying the full-erase guards.
  function automatic op_e decode_erase(input logic [7:0] b, input logic arm, input logic dbg);
    if (b == CODE_PAGE) return OP_PAGE;
    if (b == CODE_MASS && arm && dbg) return OP_MASS;
    return OP_NONE;
  endfunction

endpackage

// File: rtl/flcs_regs.sv
module flcs_regs
  import flcs_pkg::*;
#(
  parameter int PAGE_W = 7,
  parameter int FA_W   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbg_en,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            xw_en,
  input  logic            busy,
  output logic            start,
  output op_e             start_op,
  output logic [PAGE_W-1:0] page_q,
  output logic            pwe,
  output logic            ram_we
);

  localparam int PAD_W = 8 - PAGE_W;

  logic arm;
  logic refused;
  logic cmd_wr;
  logic erase_code_wr;
  logic mass_refused;
  logic prog_req;
  op_e  cmd_op;

  assign cmd_wr        = reg_wr && (reg_addr == RA_CMD) && !busy;
  assign erase_code_wr = cmd_wr && is_erase_code(reg_wdata);
  assign cmd_op        = cmd_wr ? decode_erase(reg_wdata, arm, dbg_en) : OP_NONE;
  assign mass_refused  = cmd_wr && (reg_wdata == CODE_MASS) && (cmd_op == OP_NONE);
  assign prog_req      = xw_en && pwe && !busy;
  assign ram_we        = xw_en && !pwe;

  // A command write wins over a same-cycle flash write.
  always_comb begin
    start    = 1'b0;
    start_op = OP_NONE;
    if (cmd_op != OP_NONE) begin
      start    = 1'b1;
      start_op = cmd_op;
    end else if (prog_req) begin
      start    = 1'b1;
      start_op = OP_PROG;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm     <= 1'b0;
      pwe     <= 1'b0;
      page_q  <= '0;
      refused <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == RA_CTRL) begin
        pwe <= reg_wdata[0];
        arm <= reg_wdata[1];
      end else if (erase_code_wr) begin
        arm <= 1'b0;
      end
      if (reg_wr && reg_addr == RA_PAGE) page_q <= reg_wdata[7 -: PAGE_W];
      if (mass_refused) refused <= 1'b1;
      else if (start)   refused <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {6'b0, arm, pwe};
      RA_PAGE: reg_rdata = {page_q, {PAD_W{1'b0}}};
      RA_CMD:  reg_rdata = 8'h00;
      default: reg_rdata = {6'b0, refused, busy};
    endcase
  end

  // R6
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_code_wr |=> !arm);

  // R4
  refused_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mass_refused |=> refused);

endmodule

// File: rtl/flcs_fsm.sv
module flcs_fsm
  import flcs_pkg::*;
#(
  parameter int PAGE_W   = 7,
  parameter int FA_W     = 10,
  parameter int PAGE_CYC = 12,
  parameter int MASS_CYC = 24,
  parameter int PROG_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_e               start_op,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [FA_W-1:0]   start_addr,
  input  logic [7:0]        start_data,
  output logic              busy,
  output op_e               op,
  output logic [PAGE_W-1:0] tgt_page,
  output logic [FA_W-1:0]   tgt_addr,
  output logic [7:0]        tgt_data,
  output logic              done
);

  localparam int MAX_AB = (PAGE_CYC > MASS_CYC) ? PAGE_CYC : MASS_CYC;
  localparam int MAX_C  = (MAX_AB > PROG_CYC) ? MAX_AB : PROG_CYC;
  localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] last_of(input op_e o);
    case (o)
      OP_PAGE: return CNT_W'(PAGE_CYC - 1);
      OP_MASS: return CNT_W'(MASS_CYC - 1);
      default: return CNT_W'(PROG_CYC - 1);
    endcase
  endfunction

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      op       <= OP_NONE;
      cnt      <= '0;
      tgt_page <= '0;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      op       <= start_op;
      cnt      <= last_of(start_op);
      tgt_page <= start_page;
      tgt_addr <= start_addr;
      tgt_data <= start_data;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        op   <= OP_NONE;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && busy));

  // R9
  op_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(done)) |-> $stable(op));

endmodule

// File: rtl/flcs_array.sv
module flcs_array
  import flcs_pkg::*;
#(
  parameter int PAGE_W = 7,
  parameter int OFF_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     done,
  input  op_e                      op,
  input  logic [PAGE_W-1:0]        tgt_page,
  input  logic [PAGE_W+OFF_W-1:0]  tgt_addr,
  input  logic [7:0]               tgt_data,
  input  logic [PAGE_W+OFF_W-1:0]  rd_addr,
  output logic [7:0]               rd_data
);

  localparam int FA_W       = PAGE_W + OFF_W;
  localparam int BYTES      = 1 << FA_W;
  localparam int PAGE_BYTES = 1 << OFF_W;

  logic [7:0] mem [BYTES];
  logic [7:0] cur_byte;
  logic [7:0] pg_first;
  logic [7:0] pg_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= 8'hFF;
    end else if (done) begin
      case (op)
        OP_PAGE: for (int o = 0; o < PAGE_BYTES; o++) mem[{tgt_page, OFF_W'(o)}] <= 8'hFF;
        OP_MASS: for (int i = 0; i < BYTES; i++) mem[i] <= 8'hFF;
        OP_PROG: mem[tgt_addr] <= prog_merge(mem[tgt_addr], tgt_data);
        default: ;
      endcase
    end
  end

  assign rd_data  = mem[rd_addr];
  assign cur_byte = mem[tgt_addr];
  assign pg_first = mem[{tgt_page, {OFF_W{1'b0}}}];
  assign pg_last  = mem[{tgt_page, {OFF_W{1'b1}}}];

  // R7
  prog_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_PROG) |=> ((cur_byte & ~$past(cur_byte)) == 8'h00));

  // R2
  page_erased_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_PAGE) |=> (pg_first == 8'hFF && pg_last == 8'hFF));

endmodule

// File: rtl/flcs_ram.sv
module flcs_ram #(
  parameter int RAM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RAM_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [RAM_AW-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << RAM_AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flcs_pkg::*;
#(
  parameter int PAGE_W   = 7,
  parameter int OFF_W    = 3,
  parameter int RAM_AW   = 6,
  parameter int PAGE_CYC = 12,
  parameter int MASS_CYC = 24,
  parameter int PROG_CYC = 3,
  localparam int FA_W    = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              xw_en,
  input  logic [FA_W-1:0]   xw_addr,
  input  logic [7:0]        xw_data,
  input  logic [FA_W-1:0]   fl_rd_addr,
  output logic [7:0]        fl_rd_data,
  input  logic [RAM_AW-1:0] ram_rd_addr,
  output logic [7:0]        ram_rd_data,
  output logic              fm_erase_page,
  output logic              fm_erase_all,
  output logic              fm_prog,
  output logic              fm_busy
);

  logic              busy;
  logic              start;
  op_e               start_op;
  op_e               op;
  logic [PAGE_W-1:0] page_q;
  logic              pwe;
  logic              ram_we;
  logic [PAGE_W-1:0] tgt_page;
  logic [FA_W-1:0]   tgt_addr;
  logic [7:0]        tgt_data;
  logic              done;

  flcs_regs #(.PAGE_W(PAGE_W), .FA_W(FA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xw_en(xw_en), .busy(busy),
    .start(start), .start_op(start_op), .page_q(page_q), .pwe(pwe), .ram_we(ram_we)
  );

  flcs_fsm #(.PAGE_W(PAGE_W), .FA_W(FA_W), .PAGE_CYC(PAGE_CYC),
             .MASS_CYC(MASS_CYC), .PROG_CYC(PROG_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
    .start_page(page_q), .start_addr(xw_addr), .start_data(xw_data),
    .busy(busy), .op(op), .tgt_page(tgt_page), .tgt_addr(tgt_addr),
    .tgt_data(tgt_data), .done(done)
  );

  flcs_array #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_array (
    .clk(clk), .rst_n(rst_n), .done(done), .op(op),
    .tgt_page(tgt_page), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .rd_addr(fl_rd_addr), .rd_data(fl_rd_data)
  );

  flcs_ram #(.RAM_AW(RAM_AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(xw_addr[RAM_AW-1:0]),
    .wdata(xw_data), .raddr(ram_rd_addr), .rdata(ram_rd_data)
  );

  assign fm_busy       = busy;
  assign fm_erase_page = busy && (op == OP_PAGE);
  assign fm_erase_all  = busy && (op == OP_MASS);
  assign fm_prog       = busy && (op == OP_PROG);

  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fm_erase_page, fm_erase_all, fm_prog}));

  // R9
  busy_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fm_busy |-> $countones({fm_erase_page, fm_erase_all, fm_prog}) == 1);

  // R3
  mass_needs_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fm_erase_all) |-> $past(dbg_en));

endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/100ps
module sim_flash_cmd_seq;

  localparam int PAGE_W = 7, OFF_W = 3, RAM_AW = 6;
  localparam int PAGE_CYC = 12, MASS_CYC = 24, PROG_CYC = 3;
  localparam int FA_W = PAGE_W + OFF_W;
  localparam int BYTES = 1 << FA_W;
  localparam int PB = 1 << OFF_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_en = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic xw_en = 1'b0;
  logic [FA_W-1:0] xw_addr = '0;
  logic [7:0] xw_data = 8'h00;
  logic [FA_W-1:0] fl_rd_addr = '0;
  logic [7:0] fl_rd_data;
  logic [RAM_AW-1:0] ram_rd_addr = '0;
  logic [7:0] ram_rd_data;
  logic fm_erase_page, fm_erase_all, fm_prog, fm_busy;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl [BYTES];
  logic [7:0] rmdl [1 << RAM_AW];
  logic m_arm = 1'b0, m_pwe = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_seq #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .RAM_AW(RAM_AW),
    .PAGE_CYC(PAGE_CYC), .MASS_CYC(MASS_CYC), .PROG_CYC(PROG_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xw_en(xw_en), .xw_addr(xw_addr),
    .xw_data(xw_data), .fl_rd_addr(fl_rd_addr), .fl_rd_data(fl_rd_data),
    .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data), .fm_erase_page(fm_erase_page),
    .fm_erase_all(fm_erase_all), .fm_prog(fm_prog), .fm_busy(fm_busy));

  function automatic logic [7:0] exp_prog(input logic [7:0] o, input logic [7:0] n);
    return ~(~o | ~n);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_ctrl(input logic arm, input logic pwe);
    reg_write(2'd0, {6'b0, arm, pwe});
    m_arm = arm; m_pwe = pwe;
  endtask

  task automatic x_write(input logic [FA_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    xw_en = 1'b1; xw_addr = a; xw_data = d;
    @(negedge clk);
    xw_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (fm_busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic compare_all(input string tag);
    int errs = 0;
    int first = -1;
    logic [7:0] a = 8'h00, e = 8'h00;
    for (int i = 0; i < BYTES; i++) begin
      fl_rd_addr = FA_W'(i);
      #0.1;
      if (fl_rd_data !== mdl[i]) begin
        if (first < 0) begin first = i; a = fl_rd_data; e = mdl[i]; end
        errs++;
      end
    end
    check(errs == 0, $sformatf("%s array@%0d", tag, first), a, e);
  endtask

  task automatic do_page(input int pg, input bit set_bit0);
    int n;
    reg_write(2'd1, {7'(pg), set_bit0});
    reg_write(2'd2, 8'h55);
    m_arm = 1'b0;
    check(fm_erase_page && !fm_erase_all && !fm_prog, "R9 page strobe", fm_erase_page, 1);
    wait_idle(n);
    check(n == PAGE_CYC, "R2 page busy cycles", n, PAGE_CYC);
    for (int o = 0; o < PB; o++) mdl[pg * PB + o] = 8'hFF;
  endtask

  task automatic do_prog(input int a, input logic [7:0] d);
    int n;
    x_write(FA_W'(a), d);
    check(fm_prog, "R9 prog strobe", fm_prog, 1);
    wait_idle(n);
    check(n == PROG_CYC, "R7 prog busy cycles", n, PROG_CYC);
    mdl[a] = exp_prog(mdl[a], d);
  endtask

  task automatic do_mass(input logic arm, input logic dbg);
    int n;
    logic [7:0] r;
    set_ctrl(arm, m_pwe);
    dbg_en = dbg;
    reg_write(2'd2, 8'hAA);
    m_arm = 1'b0;
    if (arm && dbg) begin
      check(fm_erase_all, "R3 mass strobe", fm_erase_all, 1);
      wait_idle(n);
      check(n == MASS_CYC, "R3 mass busy cycles", n, MASS_CYC);
      for (int i = 0; i < BYTES; i++) mdl[i] = 8'hFF;
    end else begin
      check(!fm_busy, "R4 refused stays idle", fm_busy, 0);
      reg_read(2'd3, r);
      check(r == 8'h02, "R4 refused status", r, 8'h02);
    end
    reg_read(2'd0, r);
    check(r[1] == 1'b0, "R6 arm cleared", r, {6'b0, 1'b0, m_pwe});
  endtask

  initial begin
    #600000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n;
    void'($urandom(32'd4242));
    for (int i = 0; i < BYTES; i++) mdl[i] = 8'hFF;
    for (int i = 0; i < (1 << RAM_AW); i++) rmdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!fm_busy, "R1 busy after reset", fm_busy, 0);
    reg_read(2'd0, r); check(r == 8'h00, "R1 ctrl reset", r, 0);
    reg_read(2'd1, r); check(r == 8'h00, "R1 page reset", r, 0);
    reg_read(2'd3, r); check(r == 8'h00, "R1 status reset", r, 0);
    ram_rd_addr = 6'd17; #0.1; check(ram_rd_data == 8'h00, "R1 ram reset", ram_rd_data, 0);
    compare_all("R1 erased after reset");

    // R10 register readback
    reg_write(2'd1, 8'hFF);
    reg_read(2'd1, r); check(r == 8'hFE, "R10 page bit0 reads 0", r, 8'hFE);
    set_ctrl(1'b1, 1'b1);
    reg_read(2'd0, r); check(r == 8'h03, "R10 ctrl readback", r, 8'h03);
    reg_read(2'd2, r); check(r == 8'h00, "R10 cmd reads zero", r, 0);
    set_ctrl(1'b0, 1'b1);

    // R7 program clears only
    do_prog(16'h15, 8'h3C);
    do_prog(16'h15, 8'hF0);
    fl_rd_addr = 10'h15; #0.1;
    check(fl_rd_data == 8'h30, "R7 and-merge", fl_rd_data, 8'h30);
    compare_all("R7 program");

    // R7 RAM path
    set_ctrl(1'b0, 1'b0);
    x_write(10'h15, 8'hAB); rmdl[6'h15] = 8'hAB;
    check(!fm_busy, "R7 ram write no busy", fm_busy, 0);
    ram_rd_addr = 6'h15; #0.1;
    check(ram_rd_data == 8'hAB, "R7 ram data", ram_rd_data, 8'hAB);
    compare_all("R7 ram leaves flash");

    // R4 refused full erase, both guards
    do_mass(1'b1, 1'b0);
    compare_all("R4 no dbg");
    do_mass(1'b0, 1'b1);
    compare_all("R4 no arm");

    // R5 other codes ignored
    set_ctrl(1'b0, 1'b1);
    do_prog(2 * PB + 1, 8'h11);
    do_prog(3 * PB + 4, 8'h22);
    reg_write(2'd2, 8'h12);
    check(!fm_busy, "R5 other code idle", fm_busy, 0);
    reg_write(2'd2, 8'h54);
    check(!fm_busy, "R5 near code idle", fm_busy, 0);
    compare_all("R5 other codes");

    // R2 page erase; bit0 of page byte ignored
    do_page(3, 1'b1);
    compare_all("R2 only page 3");

    // R8 writes during busy ignored
    dbg_en = 1'b1;
    reg_write(2'd1, {7'd2, 1'b0});
    reg_write(2'd2, 8'h55);
    m_arm = 1'b0;
    for (int o = 0; o < PB; o++) mdl[2 * PB + o] = 8'hFF;
    set_ctrl(1'b1, 1'b1);
    reg_read(2'd3, r); check(r[0] == 1'b1, "R8 status busy", r, 1);
    reg_write(2'd2, 8'hAA);
    x_write(10'h40, 8'h00);
    check(!fm_erase_all, "R8 no mass while busy", fm_erase_all, 0);
    wait_idle(n);
    reg_read(2'd0, r); check(r == 8'h03, "R8 arm kept", r, 8'h03);
    compare_all("R8 busy ignored");

    // R3 full erase
    do_mass(1'b1, 1'b1);
    compare_all("R3 all erased");
    reg_read(2'd3, r); check(r == 8'h00, "R4 refused cleared", r, 0);

    // R10 same-cycle command wins
    set_ctrl(1'b0, 1'b1);
    reg_write(2'd1, {7'd5, 1'b0});
    do_prog(5 * PB + 2, 8'h00);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h55;
    xw_en = 1'b1; xw_addr = 10'h7; xw_data = 8'h00;
    @(negedge clk);
    reg_wr = 1'b0; xw_en = 1'b0; m_arm = 1'b0;
    check(fm_erase_page, "R10 command priority", fm_erase_page, 1);
    wait_idle(n);
    for (int o = 0; o < PB; o++) mdl[5 * PB + o] = 8'hFF;
    compare_all("R10 command priority");

    // random mix
    for (int k = 0; k < 150; k++) begin
      int kind = $urandom_range(0, 4);
      case (kind)
        0: begin
          if (!m_pwe) set_ctrl(m_arm, 1'b1);
          do_prog($urandom_range(0, BYTES - 1), 8'($urandom));
        end
        1: begin
          int a = $urandom_range(0, BYTES - 1);
          logic [7:0] d = 8'($urandom);
          if (m_pwe) set_ctrl(m_arm, 1'b0);
          x_write(FA_W'(a), d);
          rmdl[a % (1 << RAM_AW)] = d;
          ram_rd_addr = RAM_AW'(a); #0.1;
          check(ram_rd_data == d, "R7 random ram", ram_rd_data, d);
        end
        2: do_page($urandom_range(0, (1 << PAGE_W) - 1), 1'($urandom));
        3: do_mass(($urandom_range(0, 3) == 0), 1'($urandom));
        default: begin
          logic [7:0] c = 8'($urandom);
          if (c == 8'hAA || c == 8'h55) c = 8'h00;
          reg_write(2'd2, c);
          check(!fm_busy, "R5 random code idle", fm_busy, 0);
        end
      endcase
      compare_all($sformatf("random op %0d kind %0d", k, kind));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule